// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave side of a four-wire serial bus for a flash-style memory. It watches chip select, shifts in a command opcode, a three-byte address and, for some reads, a fixed number of filler bytes, and then either streams write bytes to a memory backend or shifts backend read bytes out on the serial output. The array itself, program and erase timing and any status reporting live in the backend and are not part of this block.

All pins are oversampled by a system clock that is much faster than the serial clock. A synchronizer and edge detector turns the serial clock into rising and falling strokes. Input bits are taken on rising strokes and output bits are launched on falling strokes. On every chip-select fall the idle level of the serial clock is latched. A high level selects clock mode 3 and a low level selects mode 0, and the result is reported to the backend. The backend sees a one-cycle command strobe with opcode, address and direction. For writes it then gets a strobe per received byte. For reads it gets one request per output byte. It also gets a closing strobe when chip select rises, which tells it whether a write ended off a byte boundary and must be discarded.

Top module: `sfe_front`

## Requirements
- R1: After reset the output enable is low (output in high impedance), the detected mode reads mode 3 (`mode3_o` = 1), and no strobe is active.
- R2: At every chip-select fall, `mode3_o` takes the serial clock level seen at that moment: 1 if it was high, 0 if it was low.
- R3: The first byte after chip-select fall is the opcode. The next three bytes are the address, with the first byte forming address bits 23:16. All are shifted most significant bit first on rising serial clock edges. A recognised command produces exactly one `cmd_valid_o` pulse, one system clock long, carrying that opcode and address.
- R4: The number of filler bytes between address and read data depends on the opcode. 03h takes none, 0Bh takes one, D2h takes four and E8h takes four. The first read bit appears on the falling edge right after the last filler (or address) bit.
- R5: Read bytes come from `rd_data_i` and are shifted out most significant bit first, one bit per falling edge. One `rd_req_o` pulse is issued per byte, and `rd_data_i` must hold that byte from the cycle after the pulse.
- R6: The output enable stays low during opcode, address and filler bits, during any write command, and after chip select rises.
- R7: For write opcodes 84h and 82h, each complete byte received after the address gives one `wr_valid_o` pulse with that byte on `wr_data_o`, in arrival order.
- R8: When chip select rises after a recognised command has been strobed, `end_valid_o` pulses once. `end_abort_o` is 1 only for a write whose received bit count is not a multiple of eight.
- R9: An unrecognised opcode gives no command, write, read request or closing strobe, and never enables the output, until chip select rises.
- R10: Raising chip select in the middle of the opcode or address discards the partial command with no strobe. The next command is decoded from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, meaningful only while `so_oe_o` is high |
| so_oe_o | output | 1 | Output enable for the pad; low means high impedance |
| mode3_o | output | 1 | Clock mode detected at the last chip-select fall (1 = mode 3) |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded command |
| cmd_opcode_o | output | 8 | Opcode of the current command |
| cmd_addr_o | output | 24 | Address of the current command |
| cmd_write_o | output | 1 | Current command is a write |
| wr_valid_o | output | 1 | One-cycle strobe per received write byte |
| wr_data_o | output | 8 | Received write byte |
| rd_req_o | output | 1 | Request for the next read byte |
| rd_data_i | input | 8 | Read byte supplied by the backend |
| end_valid_o | output | 1 | One-cycle strobe when a strobed command closes |
| end_abort_o | output | 1 | Closing write ended off a byte boundary |

## Verification
The hardest case to reach from the pins is a write that closes partway through a byte. The abort decision reads the bit counter in the same cycle that the chip-select rise is detected. The stimulus therefore sweeps zero to seven trailing bits after whole data bytes, and each one ends in its own transaction. A second hard case is the leading falling edge that mode 3 puts ahead of the first opcode bit. To cover it, every read and write opcode is run with the idle clock level alternating between transactions, and the filler count per opcode is checked through the returned bytes.

// File: rtl/sfe_pkg.sv
// Shared types and opcode table for the serial flash front end.
// Assumes opcodes are eight bits and filler counts fit in DUMMY_W bits.
package sfe_pkg;

    localparam int DUMMY_W = 3;
    localparam int DUMMY_MAX = (1 << DUMMY_W) - 1;

    localparam logic [7:0] OP_RD_SLOW = 8'h03;
    localparam logic [7:0] OP_RD_FAST = 8'h0B;
    localparam logic [7:0] OP_RD_PAGE = 8'hD2;
    localparam logic [7:0] OP_RD_OLD  = 8'hE8;
    localparam logic [7:0] OP_WR_BUF  = 8'h84;
    localparam logic [7:0] OP_WR_PGM  = 8'h82;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_RDATA,
        ST_WDATA,
        ST_SKIP
    } sfe_state_e;

    typedef struct packed {
        logic               known;
        logic               is_write;
        logic [DUMMY_W-1:0] dummy;
    } op_info_t;

    // Map an opcode to its class and filler byte count.
    function automatic op_info_t op_lookup(input logic [7:0] op);
        op_info_t r;
        r = '0;
        case (op)
            OP_RD_SLOW: begin r.known = 1'b1; r.dummy = DUMMY_W'(0); end
            OP_RD_FAST: begin r.known = 1'b1; r.dummy = DUMMY_W'(1); end
            OP_RD_PAGE: begin r.known = 1'b1; r.dummy = DUMMY_W'(4); end
            OP_RD_OLD:  begin r.known = 1'b1; r.dummy = DUMMY_W'(4); end
            OP_WR_BUF:  begin r.known = 1'b1; r.is_write = 1'b1; end
            OP_WR_PGM:  begin r.known = 1'b1; r.is_write = 1'b1; end
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfe_pin_sync.sv
// Synchronizes the three serial pins into the system clock domain and
// derives chip-select and serial-clock edge strokes plus the clock mode.
// Assumes each serial clock half period lasts at least STAGES+4 clocks.
module sfe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_idle,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic mode3
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][2:0] stg;
    logic cs_s, sck_s, cs_d, sck_d;

    // Synchronizer chain, bit order {cs, sck, si}; idle values at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= 3'b110;
        end else begin
            stg[0] <= {cs_n_i, sck_i, si_i};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign cs_s  = stg[LAST][2];
    assign sck_s = stg[LAST][1];
    assign si_s  = stg[LAST][0];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b1;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign cs_idle  = cs_s;
    assign cs_fall  = cs_d & ~cs_s;
    assign cs_rise  = ~cs_d & cs_s;
    assign sck_rise = ~cs_s & ~sck_d & sck_s;
    assign sck_fall = ~cs_s & sck_d & ~sck_s;

    // Latch the serial clock idle level at each chip-select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode3 <= 1'b1;
        else if (cs_fall) mode3 <= sck_s;
    end

endmodule

// File: rtl/sfe_rx.sv
// Input shifter: gathers bits on rising strokes into bytes, MSB first.
// Assumes clear is held while chip select is inactive.
module sfe_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sck_rise,
    input  logic       si,
    output logic       byte_stb,
    output logic [7:0] byte_q,
    output logic [2:0] bit_cnt
);
    logic [6:0] sh;

    // Bit counter, shift register and byte-complete strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            bit_cnt  <= '0;
            byte_stb <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                sh      <= {sh[5:0], si};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    byte_q   <= {sh, si};
                end
            end
        end
    end

endmodule

// File: rtl/sfe_tx.sv
// Output shifter: launches one bit per falling stroke while active and
// flags when the eighth bit of a byte has left. Assumes a reload arrives
// before the next falling stroke.
module sfe_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       active,
    input  logic       sck_fall,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       so_bit,
    output logic       so_oe,
    output logic       need_next
);
    logic [7:0] sh;
    logic [2:0] cnt;

    // Shift register, bit counter and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            so_bit <= 1'b0;
            so_oe  <= 1'b0;
        end else if (clear) begin
            cnt   <= '0;
            so_oe <= 1'b0;
        end else if (load) begin
            sh <= load_byte;
        end else if (active && sck_fall) begin
            so_bit <= sh[7];
            sh     <= {sh[6:0], 1'b0};
            cnt    <= cnt + 3'd1;
            so_oe  <= 1'b1;
        end
    end

    assign need_next = active & sck_fall & (cnt == 3'd7);

endmodule

// File: rtl/sfe_ctrl.sv
// Command sequencer: decodes the opcode, gathers address and filler
// bytes, and issues command, write, read-request and closing strobes.
// Assumes byte strokes never coincide with a chip-select rise.
module sfe_ctrl #(
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_fall,
    input  logic                    cs_rise,
    input  logic                    byte_stb,
    input  logic [7:0]              byte_q,
    input  logic [2:0]              bit_cnt,
    input  logic                    tx_need_next,
    output logic                    tx_active,
    output logic                    tx_load,
    output logic                    cmd_valid,
    output logic [7:0]              cmd_opcode,
    output logic [ADDR_BYTES*8-1:0] cmd_addr,
    output logic                    cmd_write,
    output logic                    wr_valid,
    output logic [7:0]              wr_data,
    output logic                    rd_req,
    output logic                    end_valid,
    output logic                    end_abort
);
    import sfe_pkg::*;

    localparam int ADDR_W = ADDR_BYTES * 8;
    localparam int HDR_MAX = (ADDR_BYTES > DUMMY_MAX) ? ADDR_BYTES : DUMMY_MAX;
    localparam int HDR_W = $clog2(HDR_MAX + 1);

    sfe_state_e       state;
    op_info_t         dec;
    op_info_t         dec_new;
    logic [HDR_W-1:0] hdr_cnt;
    logic [HDR_W-1:0] last_dummy;
    logic [ADDR_W-1:0] addr_next;

    assign dec_new    = op_lookup(byte_q);
    assign last_dummy = HDR_W'(dec.dummy) - HDR_W'(1);
    assign addr_next  = {cmd_addr[ADDR_W-9:0], byte_q};
    assign tx_active  = (state == ST_RDATA);
    assign cmd_write  = dec.is_write;

    // Main sequencer with its strobes and captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            dec        <= '0;
            hdr_cnt    <= '0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
            wr_valid   <= 1'b0;
            wr_data    <= '0;
            rd_req     <= 1'b0;
            tx_load    <= 1'b0;
            end_valid  <= 1'b0;
            end_abort  <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            rd_req    <= 1'b0;
            end_valid <= 1'b0;
            tx_load   <= rd_req;
            if (cs_rise) begin
                if (state == ST_WDATA || state == ST_RDATA) begin
                    end_valid <= 1'b1;
                    end_abort <= dec.is_write && (bit_cnt != 3'd0);
                end
                state <= ST_IDLE;
            end else if (cs_fall) begin
                state   <= ST_OPC;
                hdr_cnt <= '0;
            end else begin
                case (state)
                    ST_OPC: if (byte_stb) begin
                        dec        <= dec_new;
                        cmd_opcode <= byte_q;
                        hdr_cnt    <= '0;
                        state      <= dec_new.known ? ST_ADDR : ST_SKIP;
                    end
                    ST_ADDR: if (byte_stb) begin
                        cmd_addr <= addr_next;
                        if (hdr_cnt == HDR_W'(ADDR_BYTES - 1)) begin
                            hdr_cnt <= '0;
                            if (dec.is_write) begin
                                cmd_valid <= 1'b1;
                                state     <= ST_WDATA;
                            end else if (dec.dummy == '0) begin
                                cmd_valid <= 1'b1;
                                rd_req    <= 1'b1;
                                state     <= ST_RDATA;
                            end else begin
                                state <= ST_DUMMY;
                            end
                        end else begin
                            hdr_cnt <= hdr_cnt + HDR_W'(1);
                        end
                    end
                    ST_DUMMY: if (byte_stb) begin
                        if (hdr_cnt == last_dummy) begin
                            cmd_valid <= 1'b1;
                            rd_req    <= 1'b1;
                            state     <= ST_RDATA;
                        end else begin
                            hdr_cnt <= hdr_cnt + HDR_W'(1);
                        end
                    end
                    ST_RDATA: if (tx_need_next) rd_req <= 1'b1;
                    ST_WDATA: if (byte_stb) begin
                        wr_valid <= 1'b1;
                        wr_data  <= byte_q;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sfe_front.sv
// Top of the serial flash command front end: pin synchronizer, input
// shifter, command sequencer and output shifter. Assumes clk runs at
// least 2*(SYNC_STAGES+4) times the serial clock rate.
module sfe_front #(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_BYTES  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n_i,
    input  logic                    sck_i,
    input  logic                    si_i,
    output logic                    so_o,
    output logic                    so_oe_o,
    output logic                    mode3_o,
    output logic                    cmd_valid_o,
    output logic [7:0]              cmd_opcode_o,
    output logic [ADDR_BYTES*8-1:0] cmd_addr_o,
    output logic                    cmd_write_o,
    output logic                    wr_valid_o,
    output logic [7:0]              wr_data_o,
    output logic                    rd_req_o,
    input  logic [7:0]              rd_data_i,
    output logic                    end_valid_o,
    output logic                    end_abort_o
);
    logic cs_idle, cs_fall, cs_rise, sck_rise, sck_fall, si_s;
    logic byte_stb;
    logic [7:0] byte_q;
    logic [2:0] bit_cnt;
    logic tx_active, tx_load, tx_need_next;
    logic shift_clear;

    assign shift_clear = cs_idle | cs_fall;

    sfe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n_i),
        .sck_i    (sck_i),
        .si_i     (si_i),
        .cs_idle  (cs_idle),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s),
        .mode3    (mode3_o)
    );

    sfe_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (shift_clear),
        .sck_rise (sck_rise),
        .si       (si_s),
        .byte_stb (byte_stb),
        .byte_q   (byte_q),
        .bit_cnt  (bit_cnt)
    );

    sfe_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_fall      (cs_fall),
        .cs_rise      (cs_rise),
        .byte_stb     (byte_stb),
        .byte_q       (byte_q),
        .bit_cnt      (bit_cnt),
        .tx_need_next (tx_need_next),
        .tx_active    (tx_active),
        .tx_load      (tx_load),
        .cmd_valid    (cmd_valid_o),
        .cmd_opcode   (cmd_opcode_o),
        .cmd_addr     (cmd_addr_o),
        .cmd_write    (cmd_write_o),
        .wr_valid     (wr_valid_o),
        .wr_data      (wr_data_o),
        .rd_req       (rd_req_o),
        .end_valid    (end_valid_o),
        .end_abort    (end_abort_o)
    );

    sfe_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (shift_clear),
        .active    (tx_active),
        .sck_fall  (sck_fall),
        .load      (tx_load),
        .load_byte (rd_data_i),
        .so_bit    (so_o),
        .so_oe     (so_oe_o),
        .need_next (tx_need_next)
    );

endmodule

// File: rtl/sfe_front_chk.sv
// Property checker for sfe_front, attached by bind below.
module sfe_front_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic so_oe_o,
    input logic mode3_o,
    input logic cmd_valid_o,
    input logic cmd_write_o,
    input logic wr_valid_o,
    input logic rd_req_o,
    input logic end_valid_o,
    input logic end_abort_o
);
    logic [3:0] idle_cnt;

    // Cycles that chip select has been continuously high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                   idle_cnt <= '0;
        else if (!cs_n_i)             idle_cnt <= '0;
        else if (idle_cnt != 4'hF)    idle_cnt <= idle_cnt + 4'd1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!so_oe_o && mode3_o && !cmd_valid_o && !end_valid_o));

    p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    p_rdreq_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !cmd_write_o);

    p_idle_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idle_cnt) >= SYNC_STAGES + 3) |-> !so_oe_o);

    p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (cmd_write_o && !so_oe_o));

    p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid_o |=> !end_valid_o);

    p_abort_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_valid_o && end_abort_o) |-> cmd_write_o);

endmodule

bind sfe_front sfe_front_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .so_oe_o     (so_oe_o),
    .mode3_o     (mode3_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_write_o (cmd_write_o),
    .wr_valid_o  (wr_valid_o),
    .rd_req_o    (rd_req_o),
    .end_valid_o (end_valid_o),
    .end_abort_o (end_abort_o)
);

// File: tb/sim_sfe_front.sv
// Bench for sfe_front: sweeps opcodes, clock modes, byte counts and
// trailing bit counts, with a behavioural backend supplying read data.
module sim_sfe_front;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b1;
    logic si = 1'b0;
    logic [7:0] rd_data = 8'h00;

    logic so, so_oe, mode3, cmd_valid, cmd_write, wr_valid, rd_req;
    logic end_valid, end_abort;
    logic [7:0] cmd_opcode, wr_data;
    logic [23:0] cmd_addr;

    int checks = 0;
    int fails = 0;

    int n_cmd, n_wr, n_rdreq, n_end;
    logic [7:0] last_op;
    logic [23:0] last_addr;
    logic last_wr, last_abort, oe_seen;
    logic [7:0] wr_buf [16];
    logic [23:0] rb_addr;
    int rb_idx;

    always #2 clk = ~clk;

    sfe_front u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n),
        .sck_i        (sck),
        .si_i         (si),
        .so_o         (so),
        .so_oe_o      (so_oe),
        .mode3_o      (mode3),
        .cmd_valid_o  (cmd_valid),
        .cmd_opcode_o (cmd_opcode),
        .cmd_addr_o   (cmd_addr),
        .cmd_write_o  (cmd_write),
        .wr_valid_o   (wr_valid),
        .wr_data_o    (wr_data),
        .rd_req_o     (rd_req),
        .rd_data_i    (rd_data),
        .end_valid_o  (end_valid),
        .end_abort_o  (end_abort)
    );

    function automatic logic [7:0] model_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] wr_pat(input int k);
        return 8'hC3 + 8'(k * 37);
    endfunction

    function automatic int fill_of(input logic [7:0] op);
        case (op)
            8'h0B:   return 1;
            8'hD2:   return 4;
            8'hE8:   return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Backend model and strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (so_oe) oe_seen = 1'b1;
        if (cmd_valid) begin
            n_cmd++;
            last_op = cmd_opcode;
            last_addr = cmd_addr;
            last_wr = cmd_write;
            rb_addr = cmd_addr;
            rb_idx = 0;
        end
        if (wr_valid) begin
            if (n_wr < 16) wr_buf[n_wr] = wr_data;
            n_wr++;
        end
        if (rd_req) begin
            rd_data = model_byte(rb_addr + 24'(rb_idx));
            rb_idx++;
            n_rdreq++;
        end
        if (end_valid) begin
            n_end++;
            last_abort = end_abort;
        end
    end

    task automatic clear_mon();
        n_cmd = 0; n_wr = 0; n_rdreq = 0; n_end = 0;
        last_abort = 1'b0; oe_seen = 1'b0; last_wr = 1'b0;
        last_op = 8'h00; last_addr = 24'h0;
    endtask

    task automatic spi_bit(input logic b, output logic o, output logic e);
        @(negedge clk);
        sck = 1'b0;
        si = b;
        repeat (7) @(negedge clk);
        o = so;
        e = so_oe;
        sck = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r, output logic any_oe);
        logic o, e;
        any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(b[i], o, e);
            r[i] = o;
            any_oe = any_oe | e;
        end
    endtask

    task automatic cs_begin(input logic m3);
        @(negedge clk);
        sck = m3;
        repeat (8) @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(mode3 == m3, "R2 mode latched at select fall", longint'(mode3), longint'(m3));
    endtask

    task automatic cs_finish(input logic m3);
        @(negedge clk);
        if (!m3) sck = 1'b0;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_header(input logic [7:0] op, input logic [23:0] a, input int fill,
                               output logic hdr_oe);
        logic [7:0] r;
        logic e;
        spi_byte(op, r, e);
        hdr_oe = e;
        spi_byte(a[23:16], r, e); hdr_oe |= e;
        spi_byte(a[15:8], r, e);  hdr_oe |= e;
        spi_byte(a[7:0], r, e);   hdr_oe |= e;
        for (int k = 0; k < fill; k++) begin
            spi_byte(8'hFF, r, e);
            hdr_oe |= e;
        end
    endtask

    task automatic do_read(input logic m3, input logic [7:0] op, input logic [23:0] a, input int nb);
        logic hdr_oe, e;
        logic [7:0] r;
        clear_mon();
        cs_begin(m3);
        send_header(op, a, fill_of(op), hdr_oe);
        chk(hdr_oe == 1'b0, "R6 no output during header", longint'(hdr_oe), 0);
        for (int k = 0; k < nb; k++) begin
            spi_byte(8'h00, r, e);
            // R4 filler count and R5 MSB-first data order
            chk(r == model_byte(a + 24'(k)), "R4 R5 read byte", longint'(r),
                longint'(model_byte(a + 24'(k))));
        end
        chk(n_cmd == 1 && last_op == op && last_addr == a && !last_wr,
            "R3 read command strobe", longint'({last_op, last_addr}), longint'({op, a}));
        chk(n_rdreq >= nb, "R5 one request per byte", longint'(n_rdreq), longint'(nb));
        cs_finish(m3);
        chk(so_oe == 1'b0, "R6 output released after select rise", longint'(so_oe), 0);
        chk(n_end == 1 && !last_abort, "R8 read close strobe", longint'(n_end), 1);
    endtask

    task automatic do_write(input logic m3, input logic [7:0] op, input logic [23:0] a,
                            input int nb, input int extra);
        logic hdr_oe, e, o;
        logic [7:0] r;
        clear_mon();
        cs_begin(m3);
        send_header(op, a, 0, hdr_oe);
        for (int k = 0; k < nb; k++) spi_byte(wr_pat(k), r, e);
        for (int k = 0; k < extra; k++) spi_bit(1'b1, o, e);
        cs_finish(m3);
        chk(n_cmd == 1 && last_op == op && last_addr == a && last_wr,
            "R3 write command strobe", longint'({last_op, last_addr}), longint'({op, a}));
        chk(n_wr == nb, "R7 write byte count", longint'(n_wr), longint'(nb));
        for (int k = 0; k < nb && k < 16; k++)
            chk(wr_buf[k] == wr_pat(k), "R7 write byte value", longint'(wr_buf[k]),
                longint'(wr_pat(k)));
        chk(n_end == 1 && last_abort == (extra != 0), "R8 write close and abort flag",
            longint'(last_abort), longint'(extra != 0));
        chk(!oe_seen, "R6 output stays off for writes", longint'(oe_seen), 0);
    endtask

    task automatic do_unknown(input logic m3, input logic [7:0] op);
        logic hdr_oe;
        clear_mon();
        cs_begin(m3);
        send_header(op, 24'h123456, 2, hdr_oe);
        cs_finish(m3);
        chk(n_cmd == 0 && n_wr == 0 && n_rdreq == 0 && n_end == 0,
            "R9 unknown opcode makes no strobe", longint'(n_cmd + n_wr + n_rdreq + n_end), 0);
        chk(!oe_seen, "R9 unknown opcode keeps output off", longint'(oe_seen), 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd_ops [4];
        logic [7:0] bad_ops [6];
        logic [23:0] addrs [2];
        logic o, e;
        logic [7:0] r;
        rd_ops = '{8'h03, 8'h0B, 8'hD2, 8'hE8};
        bad_ops = '{8'h00, 8'hFF, 8'h55, 8'h0C, 8'hD3, 8'h85};
        addrs = '{24'h01A2F3, 24'hFEDCFF};
        clear_mon();
        repeat (6) @(negedge clk);
        // R1 reset state
        chk(so_oe == 1'b0, "R1 output off in reset", longint'(so_oe), 0);
        chk(mode3 == 1'b1, "R1 mode 3 after reset", longint'(mode3), 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!cmd_valid && !end_valid && !wr_valid && !rd_req, "R1 no strobes after reset",
            longint'({cmd_valid, end_valid, wr_valid, rd_req}), 0);

        for (int i = 0; i < 4; i++)
            for (int m = 0; m < 2; m++)
                for (int j = 0; j < 2; j++)
                    do_read(logic'(m), rd_ops[i], addrs[j] + 24'(i), 3);

        for (int m = 0; m < 2; m++)
            for (int nb = 0; nb < 4; nb += 3) begin
                do_write(logic'(m), 8'h84, 24'h00A000 + 24'(nb), nb, 0);
                do_write(logic'(m), 8'h82, 24'h3F0010 + 24'(nb), nb, 0);
            end

        // R8 sweep of trailing bit counts after whole bytes
        for (int x = 0; x < 8; x++)
            do_write(logic'(x % 2), 8'h84, 24'h000100 + 24'(x), 2, x);

        for (int i = 0; i < 6; i++) do_unknown(logic'(i % 2), bad_ops[i]);

        // R10 truncated command followed by a clean read
        clear_mon();
        cs_begin(1'b0);
        spi_byte(8'h03, r, e);
        spi_byte(8'h77, r, e);
        for (int k = 0; k < 3; k++) spi_bit(1'b1, o, e);
        cs_finish(1'b0);
        chk(n_cmd == 0 && n_end == 0, "R10 truncated command discarded",
            longint'(n_cmd + n_end), 0);
        do_read(1'b1, 8'h0B, 24'h5A5A00, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule